// File: doc/BRIEF.md
# Double-Buffered Compare Timer

An 8-bit interval timer built around a free-running up counter and a compare value. The compare value is loaded through a write-only bus port. A shadow register can sit in front of the active compare register. When buffering is off, a write lands in both registers at once. When buffering is on, a write lands only in the shadow. The shadow is then copied into the active register at a point in the waveform where the change cannot cause a glitch.

Three operating modes share the counter:

- **Interval mode:** the counter restarts on each compare match, so the match period is programmable.
- **PWM mode:** the counter wraps on a 2^n period, with n chosen from 6, 7 or 8 bits. The waveform output goes high at the start of each period and low on the compare match.
- **Pulse-generator mode:** the counter restarts on each match and the waveform output toggles.

A compare value of zero means "match when the counter reaches its top count". It does not mean "match at count zero".

Top module: `dbuf_cmp_timer`

## Requirements
- R1: After reset, `matchPulse` and `waveOut` are 0, and buffering is considered off until `bufEn` is raised.
- R2: In interval mode (`modeSel`=0, or the spare code 3) with a non-zero compare value K, `matchPulse` is high for one cycle every K+1 counting cycles. The first pulse comes K+1 clock edges after `run` is sampled high.
- R3: A compare value of 00h matches on counter overflow rather than at zero. In interval mode this gives one pulse every 256 counting cycles.
- R4: With `bufEn`=0, a write updates the shadow and the active compare register at the same clock edge. The new value governs the very next comparison.
- R5: With `bufEn`=1, a write updates only the shadow. In interval mode there is no transfer event, so the active value never changes.
- R6: In PWM mode (`modeSel`=1) the period is 2^n cycles, with `pwmSel`=0/1/2 giving n=6/7/8 (3 acts as 8). A match occurs when the counter equals the compare value.
- R7: In PWM mode `waveOut` goes high on the edge that ends each period and low on a compare match; the period start wins if both happen together. With buffering on, the shadow is copied into the active register on that period-ending edge.
- R8: In pulse-generator mode (`modeSel`=2) the counter restarts on each match and `waveOut` toggles on each match. With buffering on, the shadow is copied in on that match edge.
- R9: While `run` is low the counter is held at 0, and `matchPulse` and `waveOut` are driven to 0. The next run therefore starts from a count of zero.
- R10: The bus read data `rdData` is always 00h; the compare registers cannot be read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counting enable; low clears the counter |
| modeSel | input | 2 | 0 interval, 1 PWM, 2 pulse generator, 3 interval |
| pwmSel | input | 2 | PWM period bits: 0→6, 1→7, 2/3→8 |
| bufEn | input | 1 | Shadow-buffer enable |
| wrEn | input | 1 | Compare value write strobe |
| wrData | input | WIDTH | Compare value to write |
| rdData | output | WIDTH | Read data, constant zero |
| matchPulse | output | 1 | One-cycle compare-match pulse |
| waveOut | output | 1 | Mode-dependent waveform |

## Verification
`matchPulse` and `waveOut` are both registered. Each reflects the counter value of the previous cycle, so a match on count K is seen one edge after the counter holds K; that is K+1 edges after `run` rises in interval mode. A write changes the active value at the edge that takes it, and a shadow copy changes it at the period-ending or match edge.

The bench logs every edge as a cycle number and queues the exact cycle of each expected pulse. A monitor samples on the falling clock and pops one entry for each pulse it sees. Waveform levels are sampled at cycles placed well inside a high or low phase.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_PWM      = 2'd1,
    MODE_PPG      = 2'd2,
    MODE_SPARE    = 2'd3
  } tmr_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // counter back to zero next edge
    logic xfer;     // copy shadow into active compare
  } tmr_strobe_t;

endpackage

// File: rtl/dbt_datapath.sv
module dbt_datapath
  import dbt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             bufEn,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  tmr_strobe_t      stb,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] active
);

  logic [WIDTH-1:0] shadow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!run || stb.restart) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow <= '0;
    end else if (wrEn) begin
      shadow <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= '0;
    end else if (wrEn && !bufEn) begin
      active <= wrData;
    end else if (stb.xfer) begin
      active <= shadow;
    end
  end

  // R5: buffered writes leave the active value alone between transfers
  assert_hold_buffered_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bufEn && !stb.xfer) |=> $stable(active));

  // R7 / R8: a transfer lands the previous shadow content
  assert_xfer_copies_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.xfer |=> (active == $past(shadow)));

  // R9: counter idles at zero while stopped
  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (cnt == '0));

endmodule

// File: rtl/dbt_ctrl.sv
module dbt_ctrl
  import dbt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  tmr_mode_e        mode,
  input  logic [1:0]       pwmSel,
  input  logic             bufEn,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] active,
  output tmr_strobe_t      stb,
  output logic             matchPulse,
  output logic             waveOut
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [1:0]       SEL_MAX  = 2'd2;

  logic             isPwm;
  logic             isPpg;
  logic [1:0]       selClamp;
  logic [WIDTH-1:0] pwmMask;
  logic [WIDTH-1:0] topCnt;
  logic             atTop;
  logic             cmpHit;
  logic             hit;

  always_comb begin
    isPwm    = (mode == MODE_PWM);
    isPpg    = (mode == MODE_PPG);
    selClamp = (pwmSel > SEL_MAX) ? SEL_MAX : pwmSel;
    pwmMask  = ALL_ONES >> (SEL_MAX - selClamp);
    topCnt   = isPwm ? pwmMask : ALL_ONES;
    atTop    = (cnt == topCnt);
    // zero compare means: match on overflow
    cmpHit   = (active == '0) ? atTop : (cnt == active);
    hit      = run & cmpHit;
    stb.restart = run & (isPwm ? atTop : cmpHit);
    stb.xfer    = run & bufEn & (isPwm ? atTop : (isPpg & cmpHit));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchPulse <= 1'b0;
      waveOut    <= 1'b0;
    end else begin
      matchPulse <= hit;
      if (!run) begin
        waveOut <= 1'b0;
      end else if (isPwm) begin
        if (atTop)       waveOut <= 1'b1;
        else if (cmpHit) waveOut <= 1'b0;
      end else if (isPpg) begin
        if (cmpHit) waveOut <= ~waveOut;
      end else begin
        waveOut <= 1'b0;
      end
    end
  end

  // R2: a match is never followed directly by another unless settings moved
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !wrEn) |=> (!$stable(mode) || !$stable(pwmSel) || !hit));

  // R6: PWM counter stays inside the selected period
  assert_pwm_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (isPwm && cnt <= pwmMask) |=> (!isPwm || !$stable(pwmSel) || cnt <= pwmMask));

  // R8: pulse-generator output changes exactly when a match is reported
  assert_ppg_toggle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (isPpg && run) |=> ((waveOut != $past(waveOut)) == matchPulse));

endmodule

// File: rtl/dbuf_cmp_timer.sv
module dbuf_cmp_timer
  import dbt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       pwmSel,
  input  logic             bufEn,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             matchPulse,
  output logic             waveOut
);

  tmr_strobe_t      stb;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] active;
  tmr_mode_e        mode;

  assign mode   = tmr_mode_e'(modeSel);
  assign rdData = '0;  // R10: compare registers are write-only

  dbt_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .run    (run),
    .bufEn  (bufEn),
    .wrEn   (wrEn),
    .wrData (wrData),
    .stb    (stb),
    .cnt    (cnt),
    .active (active)
  );

  dbt_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .run        (run),
    .mode       (mode),
    .pwmSel     (pwmSel),
    .bufEn      (bufEn),
    .wrEn       (wrEn),
    .cnt        (cnt),
    .active     (active),
    .stb        (stb),
    .matchPulse (matchPulse),
    .waveOut    (waveOut)
  );

endmodule

// File: tb/dbuf_cmp_timer_bench.sv
module dbuf_cmp_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         run = 1'b0;
  logic [1:0]   modeSel = 2'd0;
  logic [1:0]   pwmSel = 2'd0;
  logic         bufEn = 1'b0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic         matchPulse;
  logic         waveOut;

  dbuf_cmp_timer #(.WIDTH(W)) u_dbuf_cmp_timer (
    .clk        (clk),
    .rstN       (rstN),
    .run        (run),
    .modeSel    (modeSel),
    .pwmSel     (pwmSel),
    .bufEn      (bufEn),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .rdData     (rdData),
    .matchPulse (matchPulse),
    .waveOut    (waveOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    errors = 0;
  int    checks = 0;
  int    expCyc[$];
  string expTag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expectAt(input int c, input string tag);
    expCyc.push_back(c);
    expTag.push_back(tag);
  endtask

  // scoreboard monitor: every observed pulse consumes one expected item
  always @(negedge clk) begin
    int    c;
    string t;
    if (rstN && matchPulse) begin
      if (expCyc.size() == 0) begin
        check(1'b0, "R2", "unexpected match at cycle", cyc, -1);
      end else begin
        c = expCyc.pop_front();
        t = expTag.pop_front();
        check(c == cyc, t, "match cycle", cyc, c);
      end
    end
  end

  task automatic drain();
    while (expCyc.size() > 0) begin
      check(1'b0, expTag[0], "missing match", -1, expCyc[0]);
      void'(expCyc.pop_front());
      void'(expTag.pop_front());
    end
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic writeCmp(input logic [W-1:0] v);
    wrEn   = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic startRun(output int s);
    run = 1'b1;
    s   = cyc;
  endtask

  task automatic stopRun();
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R10: reset state and read data
    check(matchPulse == 1'b0, "R1", "matchPulse after reset", matchPulse, 0);
    check(waveOut == 1'b0, "R1", "waveOut after reset", waveOut, 0);
    check(rdData == '0, "R10", "read data after reset", rdData, 0);

    // R2 / R4: interval, compare 5, direct write
    modeSel = 2'd0; bufEn = 1'b0;
    writeCmp(8'd5);
    check(rdData == '0, "R10", "read data after write", rdData, 0);
    startRun(s);
    expectAt(s + 6, "R4"); expectAt(s + 12, "R2"); expectAt(s + 18, "R2");
    waitUntil(s + 20);
    stopRun();
    drain();

    // R5: buffered write in interval mode never reaches the compare
    bufEn = 1'b1;
    writeCmp(8'd9);
    startRun(s);
    expectAt(s + 6, "R5"); expectAt(s + 12, "R5");
    waitUntil(s + 14);
    stopRun();
    drain();
    bufEn = 1'b0;

    // R9: stopping mid-count restarts from zero
    startRun(s);
    waitUntil(s + 3);
    stopRun();
    check(matchPulse == 1'b0, "R9", "matchPulse while stopped", matchPulse, 0);
    @(negedge clk);
    startRun(s);
    expectAt(s + 6, "R9");
    waitUntil(s + 8);
    stopRun();
    drain();

    // R3: zero compare matches on overflow
    writeCmp(8'd0);
    startRun(s);
    expectAt(s + 256, "R3"); expectAt(s + 512, "R3");
    waitUntil(s + 515);
    stopRun();
    drain();

    // R6 / R7: PWM n=6, buffered update copied at period end
    modeSel = 2'd1; pwmSel = 2'd0; bufEn = 1'b0;
    writeCmp(8'd16);
    bufEn = 1'b1;
    startRun(s);
    expectAt(s + 17, "R6"); expectAt(s + 105, "R7");
    expectAt(s + 169, "R7"); expectAt(s + 233, "R6");
    waitUntil(s + 10);
    check(waveOut == 1'b0, "R7", "wave before first period end", waveOut, 0);
    waitUntil(s + 29);
    writeCmp(8'd40);
    waitUntil(s + 70);
    check(waveOut == 1'b1, "R7", "wave after period start", waveOut, 1);
    waitUntil(s + 90);
    check(waveOut == 1'b1, "R7", "wave still high with new compare", waveOut, 1);
    waitUntil(s + 110);
    check(waveOut == 1'b0, "R7", "wave after compare match", waveOut, 0);
    waitUntil(s + 240);
    stopRun();
    check(waveOut == 1'b0, "R9", "wave cleared on stop", waveOut, 0);
    drain();

    // R6: PWM n=7
    bufEn = 1'b0; pwmSel = 2'd1;
    writeCmp(8'd100);
    startRun(s);
    expectAt(s + 101, "R6"); expectAt(s + 229, "R6");
    waitUntil(s + 235);
    stopRun();
    drain();

    // R8: pulse generator, compare 3 then buffered 7
    modeSel = 2'd2; bufEn = 1'b0;
    writeCmp(8'd3);
    bufEn = 1'b1;
    startRun(s);
    expectAt(s + 4, "R8"); expectAt(s + 8, "R8");
    expectAt(s + 16, "R8"); expectAt(s + 24, "R8");
    waitUntil(s + 5);
    check(waveOut == 1'b1, "R8", "wave after first match", waveOut, 1);
    writeCmp(8'd7);
    waitUntil(s + 12);
    check(waveOut == 1'b0, "R8", "wave after second match", waveOut, 0);
    waitUntil(s + 20);
    check(waveOut == 1'b1, "R8", "wave after buffered period", waveOut, 1);
    waitUntil(s + 26);
    stopRun();
    check(waveOut == 1'b0, "R9", "wave cleared on stop", waveOut, 0);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule